// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits between a clock synthesizer and the output pads. It turns derived clocks on and off in three groups. A fast group of processor clocks, which also carries the graphics-port clocks, stops on one active-low request. A slower group of bus clocks stops on a second request. A single free-running bus clock never responds to either request. Each request arrives with no timing relation to the clocks. It passes through a per-group flop chain in the domain of the clock it gates. It reaches the output through an enable that can change only while that clock is low. As a result, a gated output is either a full clock pulse or a solid low. It never produces a shortened pulse.

Software-style enable bits hold any single output low, whatever the stop requests are doing. A strap input selects low-power mode. When the strap is low, the requests are ignored and all groups run. After a restart, each stoppable group must run for a minimum number of its own clocks before another stop may take effect. A global high-impedance control forces all data outputs low and drops the pad output enable.

Top module: `clk_stop_gate`

## Requirements
- R1: The processor group samples its stop request through two flops. The request is the fast stop input low while the mobile strap is 1. If the request is present at rising edge e0, the high phases that begin at e0, e1 and e2 still appear, and no high phase appears from e3 on. Clearing the request before e0 brings the first high phase back at e3.
- R2: The bus group samples its request through one flop. If the request is present at bus-clock edge e0, the high phases at e0 and e1 appear and the high phase at e2 is suppressed. Clearing the request before e0 brings the first high phase back at e2.
- R3: Every gated output is low during every low phase of its clock. During each high phase the output is either high for the whole phase or low for the whole phase. While a group is stopped, its outputs stay low.
- R4: After a group restarts, a pending stop cannot take effect until the group has run for at least MIN_RUN clocks. MIN_RUN is 100 for the processor group and 10 for the bus group. After reset the count counts as already met.
- R5: When the mobile strap (mobile_i) is 0, both stop inputs have no effect and every enabled output keeps toggling.
- R6: An enable bit of 0 holds its output low whatever the stop inputs do. An enable bit sampled at rising edge e0 governs the high phase that begins at e1.
- R7: The free-running bus output ignores both stop inputs. It is controlled only by its own enable bit, with the timing given in R6.
- R8: Stopping one group has no effect on the other group or on the free-running output.
- R9: While hiz_i is 1, pad_oe_o is 0 and every clock output is 0, with no clock delay. When hiz_i returns to 0, the outputs follow their gates again.
- R10: While rst_ni is low, every clock output is 0. After release, each enabled output produces its first pulse on the second rising edge of its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Source clock of the processor group |
| pci_clk_i | input | 1 | Source clock of the bus group and the free output |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mobile_i | input | 1 | Strap: 1 enables the stop inputs, 0 ignores them |
| cpu_stop_ni | input | 1 | Asynchronous active-low stop request, processor group |
| pci_stop_ni | input | 1 | Asynchronous active-low stop request, bus group |
| cpu_en_i | input | CPU_N | Per-output enables, processor group |
| pci_en_i | input | PCI_N | Per-output enables, bus group |
| pcif_en_i | input | 1 | Enable of the free-running bus output |
| hiz_i | input | 1 | Forces all outputs into the high-impedance state |
| cpu_clk_o | output | CPU_N | Gated processor-group clocks |
| pci_clk_o | output | PCI_N | Gated bus-group clocks |
| pcif_clk_o | output | 1 | Free-running bus clock |
| pad_oe_o | output | 1 | Pad output enable, low while the outputs are in high impedance |

## Verification
A run-state register stuck in the wrong value shows up within one clock as a missing pulse, or as a pulse where the model expects low. An off-by-one in the synchronizer depth shifts the first missing or first restored high phase by exactly one edge. An off-by-one in the minimum-run counter shifts the stop point at the end of a short restart window by one clock. An enable that updates on the rising edge instead of the falling edge cuts a high phase short. The checks taken mid-phase and during the low phase catch this on the first edge where the enable changes.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;

   // run state of one stoppable group
   typedef enum logic {
      GATE_HALT = 1'b0,
      GATE_RUN  = 1'b1
   } gate_state_e;

   // bits needed to hold a count from 0 up to lim
   function automatic int cnt_bits(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/cg_stop_sync.sv
`timescale 1ns/1ps
module cg_stop_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic req_o
);

   logic [STAGES-1:0] pipe_q;

   initial assert (STAGES >= 1 && STAGES <= 4)
      else $error("cg_stop_sync: STAGES out of range");

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pipe_q <= '0;
            else         pipe_q <= req_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pipe_q <= '0;
            else         pipe_q <= {pipe_q[STAGES-2:0], req_i};
         end
      end
   endgenerate

   assign req_o = pipe_q[STAGES-1];

endmodule

// File: rtl/cg_run_ctrl.sv
`timescale 1ns/1ps
module cg_run_ctrl
   import cg_pkg::*;
#(
   parameter int unsigned MIN_RUN = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic halt_req_i,
   output logic run_o
);

   localparam int CW = cnt_bits(MIN_RUN);
   localparam logic [CW-1:0] LIM  = CW'(MIN_RUN);
   localparam logic [CW-1:0] LAST = CW'(MIN_RUN - 1);

   gate_state_e    st_q, st_d;
   logic [CW-1:0]  cnt_q;

   initial assert (MIN_RUN >= 1)
      else $error("cg_run_ctrl: MIN_RUN must be at least 1");

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         GATE_RUN:  if (halt_req_i && cnt_q >= LAST) st_d = GATE_HALT;
         GATE_HALT: if (!halt_req_i)                 st_d = GATE_RUN;
         default:   st_d = GATE_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= GATE_RUN;
         cnt_q <= LIM;
      end else begin
         st_q <= st_d;
         if (st_q == GATE_RUN) cnt_q <= (cnt_q == LIM) ? LIM : cnt_q + CW'(1);
         else                  cnt_q <= '0;
      end
   end

   assign run_o = (st_q == GATE_RUN);

   // independent count of consecutive running cycles, for the checks only
   int unsigned chk_run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    chk_run_q <= MIN_RUN;
      else if (run_o) chk_run_q <= (chk_run_q < MIN_RUN) ? chk_run_q + 1 : chk_run_q;
      else            chk_run_q <= 0;
   end

   // R4: a group never halts before it has run MIN_RUN clocks
   a_r4_min_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_o) |-> (chk_run_q >= MIN_RUN));

   // R1: a cleared request always leaves the group running on the next edge
   a_r1_release_resumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !halt_req_i |=> run_o);

endmodule

// File: rtl/cg_out_gate.sv
`timescale 1ns/1ps
module cg_out_gate #(
   parameter int unsigned N = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] gclk_o
);

   logic [N-1:0] mask_q;

   initial assert (N >= 1 && N <= 64)
      else $error("cg_out_gate: N out of range");

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= en_i;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic en_fall_q;

         // enable moves only on the falling edge, so it is stable for the whole high phase
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) en_fall_q <= 1'b0;
            else         en_fall_q <= run_i & mask_q[i];
         end

         assign gclk_o[i] = clk_i & en_fall_q;

         // R6: a disabled output shows no pulse in the next high phase
         a_r6_mask_low: assert property (@(negedge clk_i) disable iff (!rst_ni)
            !$past(mask_q[i]) |-> !gclk_o[i]);

         // R3: a halted group shows no pulse in the next high phase
         a_r3_halt_low: assert property (@(negedge clk_i) disable iff (!rst_ni)
            !$past(run_i) |-> !gclk_o[i]);
      end
   endgenerate

endmodule

// File: rtl/cg_group.sv
`timescale 1ns/1ps
module cg_group #(
   parameter int unsigned N         = 4,
   parameter bit          STOPPABLE = 1'b1,
   parameter int unsigned SYNC      = 2,
   parameter int unsigned MIN_RUN   = 100
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         mobile_i,
   input  logic         stop_ni,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] gclk_o
);

   logic run;

   generate
      if (STOPPABLE) begin : g_stop
         logic raw_req, sync_req;

         assign raw_req = mobile_i & ~stop_ni;

         cg_stop_sync #(.STAGES(SYNC)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (raw_req),
            .req_o  (sync_req)
         );

         cg_run_ctrl #(.MIN_RUN(MIN_RUN)) u_run (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .halt_req_i (sync_req),
            .run_o      (run)
         );
      end else begin : g_free
         logic unused_stop_inputs;
         assign unused_stop_inputs = mobile_i ^ stop_ni;
         assign run = 1'b1;
      end
   endgenerate

   cg_out_gate #(.N(N)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .en_i   (en_i),
      .gclk_o (gclk_o)
   );

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
   parameter int unsigned CPU_N       = 6,
   parameter int unsigned PCI_N       = 5,
   parameter int unsigned CPU_SYNC    = 2,
   parameter int unsigned PCI_SYNC    = 1,
   parameter int unsigned CPU_MIN_RUN = 100,
   parameter int unsigned PCI_MIN_RUN = 10
) (
   input  logic             cpu_clk_i,
   input  logic             pci_clk_i,
   input  logic             rst_ni,
   input  logic             mobile_i,
   input  logic             cpu_stop_ni,
   input  logic             pci_stop_ni,
   input  logic [CPU_N-1:0] cpu_en_i,
   input  logic [PCI_N-1:0] pci_en_i,
   input  logic             pcif_en_i,
   input  logic             hiz_i,
   output logic [CPU_N-1:0] cpu_clk_o,
   output logic [PCI_N-1:0] pci_clk_o,
   output logic             pcif_clk_o,
   output logic             pad_oe_o
);

   logic [CPU_N-1:0] cpu_g;
   logic [PCI_N-1:0] pci_g;
   logic [0:0]       free_g;
   logic [0:0]       free_en;

   assign free_en = pcif_en_i;

   cg_group #(.N(CPU_N), .STOPPABLE(1'b1), .SYNC(CPU_SYNC), .MIN_RUN(CPU_MIN_RUN)) u_cpu (
      .clk_i    (cpu_clk_i),
      .rst_ni   (rst_ni),
      .mobile_i (mobile_i),
      .stop_ni  (cpu_stop_ni),
      .en_i     (cpu_en_i),
      .gclk_o   (cpu_g)
   );

   cg_group #(.N(PCI_N), .STOPPABLE(1'b1), .SYNC(PCI_SYNC), .MIN_RUN(PCI_MIN_RUN)) u_pci (
      .clk_i    (pci_clk_i),
      .rst_ni   (rst_ni),
      .mobile_i (mobile_i),
      .stop_ni  (pci_stop_ni),
      .en_i     (pci_en_i),
      .gclk_o   (pci_g)
   );

   cg_group #(.N(1), .STOPPABLE(1'b0), .SYNC(1), .MIN_RUN(1)) u_free (
      .clk_i    (pci_clk_i),
      .rst_ni   (rst_ni),
      .mobile_i (mobile_i),
      .stop_ni  (1'b1),
      .en_i     (free_en),
      .gclk_o   (free_g)
   );

   // high impedance: data parked low, pad driver disabled
   assign cpu_clk_o  = hiz_i ? '0   : cpu_g;
   assign pci_clk_o  = hiz_i ? '0   : pci_g;
   assign pcif_clk_o = hiz_i ? 1'b0 : free_g[0];
   assign pad_oe_o   = ~hiz_i;

endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;

   localparam int CN = 6, PN = 5, CS = 2, PS = 1, CM = 100, PM = 10;

   logic cpu_clk = 1'b0, pci_clk = 1'b0, rst_n = 1'b0;
   logic mobile = 1'b1, cstop_n = 1'b1, pstop_n = 1'b1, hiz = 1'b0;
   logic [CN-1:0] cen = '1;
   logic [PN-1:0] pen = '1;
   logic fen = 1'b1;
   logic [CN-1:0] cpu_o;
   logic [PN-1:0] pci_o;
   logic free_o, oe_o;

   always #4 cpu_clk = ~cpu_clk;   // 125 MHz
   always #8 pci_clk = ~pci_clk;

   clk_stop_gate u0 (
      .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .rst_ni(rst_n), .mobile_i(mobile),
      .cpu_stop_ni(cstop_n), .pci_stop_ni(pstop_n), .cpu_en_i(cen), .pci_en_i(pen),
      .pcif_en_i(fen), .hiz_i(hiz), .cpu_clk_o(cpu_o), .pci_clk_o(pci_o),
      .pcif_clk_o(free_o), .pad_oe_o(oe_o)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   string tc = "R10", tp = "R10", tf = "R10";

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // processor-group reference model
   bit c_q[$];
   bit c_run;
   int c_cnt;
   logic [CN-1:0] c_next, c_now;
   always @(posedge cpu_clk) begin
      if (!rst_n) begin
         c_q = {};
         for (int i = 0; i < CS; i++) c_q.push_back(1'b0);
         c_run = 1'b1; c_cnt = CM; c_next = '0; c_now = '0;
      end else begin : c_step
         bit req, nrun;
         req = c_q.pop_front();
         c_q.push_back(mobile & ~cstop_n);
         if (c_run) nrun = !(req && c_cnt >= CM - 1);
         else       nrun = !req;
         c_cnt = c_run ? ((c_cnt < CM) ? c_cnt + 1 : CM) : 0;
         c_run = nrun;
         c_now = c_next;
         c_next = nrun ? cen : '0;
      end
      #2;
      chk(tc, 32'(cpu_o), hiz ? 32'd0 : 32'(c_now));
      chk(tc, 32'(oe_o), 32'(!hiz));
      #4;
      chk("R3", 32'(cpu_o), 32'd0);
   end

   // bus-group and free-output reference model
   bit p_q[$];
   bit p_run;
   int p_cnt;
   logic [PN-1:0] p_next, p_now;
   logic f_next, f_now;
   always @(posedge pci_clk) begin
      if (!rst_n) begin
         p_q = {};
         for (int i = 0; i < PS; i++) p_q.push_back(1'b0);
         p_run = 1'b1; p_cnt = PM; p_next = '0; p_now = '0; f_next = 1'b0; f_now = 1'b0;
      end else begin : p_step
         bit req, nrun;
         req = p_q.pop_front();
         p_q.push_back(mobile & ~pstop_n);
         if (p_run) nrun = !(req && p_cnt >= PM - 1);
         else       nrun = !req;
         p_cnt = p_run ? ((p_cnt < PM) ? p_cnt + 1 : PM) : 0;
         p_run = nrun;
         p_now = p_next;
         p_next = nrun ? pen : '0;
         f_now = f_next;
         f_next = fen;
      end
      #3;
      chk(tp, 32'(pci_o), hiz ? 32'd0 : 32'(p_now));
      chk(tf, 32'(free_o), hiz ? 32'd0 : 32'(f_now));
      #8;
      chk("R3", 32'(pci_o), 32'd0);
      chk("R3", 32'(free_o), 32'd0);
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge cpu_clk);
      #1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait_cyc(5);                                   // R10 reset state
      rst_n = 1'b1; tc = "R3"; tp = "R3"; tf = "R7";
      wait_cyc(20);
      // R1 processor stop and restart; bus group must not notice (R8)
      tc = "R1"; tp = "R8";
      cstop_n = 1'b0; wait_cyc(30);
      cstop_n = 1'b1; wait_cyc(20);
      // R2 bus stop and restart; processor group must not notice (R8)
      tc = "R8"; tp = "R2";
      pstop_n = 1'b0; wait_cyc(40);
      pstop_n = 1'b1; wait_cyc(30);
      // R4 stop pending right after a restart
      tc = "R4"; tp = "R4";
      cstop_n = 1'b0; pstop_n = 1'b0; wait_cyc(20);
      cstop_n = 1'b1; pstop_n = 1'b1; wait_cyc(6);
      cstop_n = 1'b0; pstop_n = 1'b0; wait_cyc(220);
      cstop_n = 1'b1; pstop_n = 1'b1; wait_cyc(20);
      // R5 desktop mode ignores the stop inputs
      tc = "R5"; tp = "R5";
      mobile = 1'b0; wait_cyc(4);
      cstop_n = 1'b0; pstop_n = 1'b0; wait_cyc(40);
      cstop_n = 1'b1; pstop_n = 1'b1; wait_cyc(4);
      mobile = 1'b1; wait_cyc(10);
      // R6 enable mask, also while stop requests come and go
      tc = "R6"; tp = "R6"; tf = "R6";
      cen = 6'b101010; pen = 5'b00110; fen = 1'b0; wait_cyc(20);
      cstop_n = 1'b0; pstop_n = 1'b0; wait_cyc(30);
      cstop_n = 1'b1; pstop_n = 1'b1; wait_cyc(20);
      cen = 6'b010101; pen = 5'b11001; fen = 1'b1; wait_cyc(20);
      cen = '1; pen = '1; wait_cyc(10);
      // R7 free output keeps running through a bus stop
      tf = "R7"; tp = "R2";
      pstop_n = 1'b0; wait_cyc(30);
      pstop_n = 1'b1; wait_cyc(20);
      // R9 high impedance override
      tc = "R9"; tp = "R9"; tf = "R9";
      hiz = 1'b1; wait_cyc(12);
      hiz = 1'b0; wait_cyc(12);
      done = 1'b1;
      finish_run();
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog: actual run still busy, expected finished");
         finish_run();
      end
   end

endmodule